// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. Each cycle it can accept one operation. An operation is two 16-bit operands plus a small opcode. The opcode chooses one of two 40-bit accumulators and says whether the product is added to it, subtracted from it, or loaded into it, or whether the accumulator is cleared. A sign-control bit selects whether the operands are read as two's-complement or unsigned values. Either way they are extended to 17 bits, so a single 17x17 multiplier serves both cases. A fractional-mode bit doubles the product before it reaches the accumulator.

The accumulators carry eight guard bits above the 32-bit output range, so intermediate sums may leave that range and come back without losing information. Every operation produces one output word, taken from the accumulator it has just written. On the way out the value may be passed as is, truncated to its upper half, or rounded to its upper half. It is then clamped to the signed 32-bit range, with flags for saturation and for a zero result. Reading an accumulator without changing it is done by adding a zero product.

The pipeline has four register stages:
- The operands and control are captured at the input.
- The product is formed in a product register.
- The accumulator is updated.
- The output word is registered.

Top module: `sat_mac`

## Requirements
- R1: After reset, both accumulators hold zero, and `outValid`, `outWord`, `outOvf` and `outZero` are all zero.
- R2: An operation sampled with `inValid` high at clock edge k has its result on the outputs after edge k+3, with `outValid` high for that cycle. A new operation may be issued on every cycle, and each one yields its own result in issue order.
- R3: With `signedMode`=1 both operands are two's-complement 16-bit values. With `signedMode`=0 both are unsigned 16-bit values. In both cases the product is exact.
- R4: With `fracMode`=1 the product is multiplied by two before it is applied to the accumulator.
- R5: `opCode` 2'b00 adds the product to the selected accumulator, 2'b01 subtracts it, 2'b10 clears the accumulator to zero, and 2'b11 loads the product into it.
- R6: `accSel`=0 selects accumulator A and `accSel`=1 selects accumulator B. The accumulator that is not selected keeps its value.
- R7: Accumulators are 40-bit two's-complement and wrap modulo 2^40. A value outside the 32-bit range is kept exactly, so later operations can bring it back into range.
- R8: `postMode` 2'b00 and 2'b11 pass the accumulator unchanged. 2'b01 clears its low 16 bits (truncation). 2'b10 adds 0x8000 and then clears the low 16 bits (round half up). These steps are applied before saturation, and the accumulator itself is never modified by them.
- R9: When the post-processed value is above 2^31-1, `outWord` is 0x7FFFFFFF. When it is below -2^31, `outWord` is 0x80000000. In both cases `outOvf` is 1; otherwise `outOvf` is 0.
- R10: `outZero` is 1 exactly when the delivered `outWord` is zero.
- R11: In a cycle with no result (`outValid`=0), `outWord`, `outOvf` and `outZero` keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue an operation this cycle |
| opA | input | 16 | First multiplier operand |
| opB | input | 16 | Second multiplier operand |
| signedMode | input | 1 | 1: operands are signed, 0: operands are unsigned |
| fracMode | input | 1 | 1: double the product |
| accSel | input | 1 | Accumulator select (0 = A, 1 = B) |
| opCode | input | 2 | 00 add, 01 subtract, 10 clear, 11 load |
| postMode | input | 2 | 00/11 pass, 01 truncate, 10 round |
| outValid | output | 1 | A result is present this cycle |
| outWord | output | 32 | Saturated, post-processed accumulator value |
| outOvf | output | 1 | The result was clamped |
| outZero | output | 1 | The result word is zero |

## Verification
The hardest state to reach from the ports is an accumulator whose value sits in the guard bits. That covers the case where it has wrapped past 2^39, and the case where it returns into the 32-bit range after saturated readings. Only long runs of unsigned full-scale products reach it.

The stimulus gets there in two ways. It stacks many 0xFFFF x 0xFFFF products into one accumulator, in both plain and fractional mode, and then subtracts them back out. It also builds values just below a rounding boundary from a fractional load followed by a small add, so that rounding carries into saturation. A behavioural model tracks both accumulators as 40-bit values and predicts every output cycle, including cycles where outputs must hold. It is then exercised with a long back-to-back stream of mixed operations that alternate between accumulators.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  localparam int NUM_ACC = 2;
  localparam int SEL_W   = $clog2(NUM_ACC);

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CLR  = 2'b10,
    OP_LOAD = 2'b11
  } acc_op_e;

  typedef enum logic [1:0] {
    POST_PASS  = 2'b00,
    POST_TRUNC = 2'b01,
    POST_ROUND = 2'b10,
    POST_ALT   = 2'b11
  } post_e;

  // strobes from control to datapath, each aligned to the stage it drives
  typedef struct packed {
    logic               ldOps;
    logic               signOps;
    logic               mulEn;
    logic               fracShift;
    logic [NUM_ACC-1:0] accWr;
    acc_op_e            accOp;
    logic               outEn;
    logic [SEL_W-1:0]   outSel;
    post_e              postMode;
  } mac_strobe_t;

endpackage

// File: rtl/sat_mac_ctrl.sv
module sat_mac_ctrl
  import sat_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             signedMode,
  input  logic             fracMode,
  input  logic [SEL_W-1:0] accSel,
  input  logic [1:0]       opCode,
  input  logic [1:0]       postMode,
  output mac_strobe_t      strobe
);

  // stage 1: operands registered, product being formed
  logic             s1Valid, s1Frac;
  logic [SEL_W-1:0] s1Sel;
  acc_op_e          s1Op;
  post_e            s1Post;
  // stage 2: product registered, accumulator being written
  logic             s2Valid;
  logic [SEL_W-1:0] s2Sel;
  acc_op_e          s2Op;
  post_e            s2Post;
  // stage 3: accumulator written, output being formed
  logic             s3Valid;
  logic [SEL_W-1:0] s3Sel;
  post_e            s3Post;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Frac  <= 1'b0;
      s1Sel   <= '0;
      s1Op    <= OP_ADD;
      s1Post  <= POST_PASS;
      s2Valid <= 1'b0;
      s2Sel   <= '0;
      s2Op    <= OP_ADD;
      s2Post  <= POST_PASS;
      s3Valid <= 1'b0;
      s3Sel   <= '0;
      s3Post  <= POST_PASS;
    end else begin
      s1Valid <= inValid;
      s1Frac  <= fracMode;
      s1Sel   <= accSel;
      s1Op    <= acc_op_e'(opCode);
      s1Post  <= post_e'(postMode);
      s2Valid <= s1Valid;
      s2Sel   <= s1Sel;
      s2Op    <= s1Op;
      s2Post  <= s1Post;
      s3Valid <= s2Valid;
      s3Sel   <= s2Sel;
      s3Post  <= s2Post;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.ldOps     = inValid;
    strobe.signOps   = signedMode;
    strobe.mulEn     = s1Valid;
    strobe.fracShift = s1Frac;
    for (int i = 0; i < NUM_ACC; i++) begin
      strobe.accWr[i] = s2Valid && (s2Sel == SEL_W'(i));
    end
    strobe.accOp     = s2Op;
    strobe.outEn     = s3Valid;
    strobe.outSel    = s3Sel;
    strobe.postMode  = s3Post;
  end

  // R2: an output strobe is only ever raised three edges after an issue
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outEn |-> $past(inValid, 3));

endmodule

// File: rtl/sat_mac_dp.sv
module sat_mac_dp
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mac_strobe_t      strobe,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic             outValid,
  output logic [OUT_W-1:0] outWord,
  output logic             outOvf,
  output logic             outZero
);

  localparam int MUL_W  = OP_W + 1;      // operand after sign control
  localparam int FULL_W = 2 * MUL_W;     // exact product
  localparam int PROD_W = FULL_W + 1;    // room for fractional doubling
  localparam int SUM_W  = ACC_W + 1;     // room for the rounding carry
  localparam int HALF_W = OUT_W / 2;
  localparam int HI_W   = SUM_W - OUT_W + 1;
  localparam logic [OUT_W-1:0] MAX_W = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_W = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [SUM_W-1:0] RND_K = {{(SUM_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  // ---------------- operand stage ----------------
  logic signed [MUL_W-1:0] opReg [2];
  logic [OP_W-1:0]         opIn  [2];
  assign opIn[0] = opA;
  assign opIn[1] = opB;

  for (genvar k = 0; k < 2; k++) begin : gOperand
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             opReg[k] <= '0;
      else if (strobe.ldOps) opReg[k] <= {strobe.signOps & opIn[k][OP_W-1], opIn[k]};
    end
  end

  // ---------------- product stage ----------------
  logic signed [FULL_W-1:0] mulFull;
  logic signed [PROD_W-1:0] prodNext, prodReg;

  assign mulFull  = FULL_W'(opReg[0]) * FULL_W'(opReg[1]);
  assign prodNext = strobe.fracShift ? {mulFull, 1'b0} : {mulFull[FULL_W-1], mulFull};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             prodReg <= '0;
    else if (strobe.mulEn) prodReg <= prodNext;
  end

  // ---------------- accumulate stage ----------------
  logic signed [ACC_W-1:0] prodExt;
  logic signed [ACC_W-1:0] accQ [NUM_ACC];

  assign prodExt = ACC_W'(prodReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ACC; i++) accQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_ACC; i++) begin
        if (strobe.accWr[i]) begin
          unique case (strobe.accOp)
            OP_ADD:  accQ[i] <= accQ[i] + prodExt;
            OP_SUB:  accQ[i] <= accQ[i] - prodExt;
            OP_CLR:  accQ[i] <= '0;
            OP_LOAD: accQ[i] <= prodExt;
            default: accQ[i] <= accQ[i];
          endcase
        end
      end
    end
  end

  // ---------------- output stage ----------------
  logic signed [ACC_W-1:0] selAcc;
  logic signed [SUM_W-1:0] postVal;
  logic [HI_W-1:0]         hiBits;
  logic                    inRange;
  logic [OUT_W-1:0]        satWord;

  assign selAcc = accQ[strobe.outSel];

  always_comb begin
    postVal = SUM_W'(selAcc);
    unique case (strobe.postMode)
      POST_TRUNC: postVal[HALF_W-1:0] = '0;
      POST_ROUND: begin
        postVal = postVal + RND_K;
        postVal[HALF_W-1:0] = '0;
      end
      default: ;
    endcase
  end

  assign hiBits  = postVal[SUM_W-1:OUT_W-1];
  assign inRange = (&hiBits) || !(|hiBits);
  assign satWord = inRange ? postVal[OUT_W-1:0] : (postVal[SUM_W-1] ? MIN_W : MAX_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outOvf   <= 1'b0;
      outZero  <= 1'b0;
    end else begin
      outValid <= strobe.outEn;
      if (strobe.outEn) begin
        outWord <= satWord;
        outOvf  <= !inRange;
        outZero <= (satWord == '0);
      end
    end
  end

  // ---------------- assertions ----------------
  assert_frac_even_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mulEn && strobe.fracShift) |=> (prodReg[0] == 1'b0));

  for (genvar g = 0; g < NUM_ACC; g++) begin : gAccChk
    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.accWr[g] && strobe.accOp == OP_CLR) |=> (accQ[g] == '0));
    assert_unselected_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.accWr[g] |=> $stable(accQ[g]));
  end

  assert_low_half_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outEn && (strobe.postMode == POST_TRUNC || strobe.postMode == POST_ROUND))
      |=> (outOvf || outWord[HALF_W-1:0] == '0));

  assert_clamp_value_R9: assert property (@(posedge clk) disable iff (!rstN)
    outOvf |-> (outWord == MAX_W || outWord == MIN_W));

  assert_zero_not_ovf_R10: assert property (@(posedge clk) disable iff (!rstN)
    outZero |-> !outOvf);

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.outEn |=> ($stable(outWord) && $stable(outOvf) && $stable(outZero)));

endmodule

// File: rtl/sat_mac.sv
module sat_mac
  import sat_mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             signedMode,
  input  logic             fracMode,
  input  logic             accSel,
  input  logic [1:0]       opCode,
  input  logic [1:0]       postMode,
  output logic             outValid,
  output logic [OUT_W-1:0] outWord,
  output logic             outOvf,
  output logic             outZero
);

  mac_strobe_t strobe;

  sat_mac_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .signedMode (signedMode),
    .fracMode   (fracMode),
    .accSel     (accSel),
    .opCode     (opCode),
    .postMode   (postMode),
    .strobe     (strobe)
  );

  sat_mac_dp #(
    .OP_W  (OP_W),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .outWord  (outWord),
    .outOvf   (outOvf),
    .outZero  (outZero)
  );

endmodule

// File: tb/sat_mac_bench.sv
`timescale 1ns/1ps
module sat_mac_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        signedMode = 1'b0, fracMode = 1'b0, accSel = 1'b0;
  logic [1:0]  opCode = '0, postMode = '0;
  logic        outValid, outOvf, outZero;
  logic [31:0] outWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sat_mac u_sat_mac (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .signedMode(signedMode), .fracMode(fracMode), .accSel(accSel),
    .opCode(opCode), .postMode(postMode), .outValid(outValid),
    .outWord(outWord), .outOvf(outOvf), .outZero(outZero)
  );

  // behavioural reference: two 40-bit accumulators and a result delay line
  logic signed [39:0] mAcc [2];
  bit          sv [1:4];
  logic [31:0] sw [1:4];
  bit          so [1:4];
  bit          sz [1:4];
  string       st [1:4];
  logic [31:0] hW = '0;
  bit          hO = 0, hZ = 0;

  task automatic compare(string tag);
    checks++;
    if (outValid !== sv[4] || outWord !== hW || outOvf !== hO || outZero !== hZ) begin
      failures++;
      $display("FAIL %s: actual valid=%0b word=%h ovf=%0b zero=%0b expected valid=%0b word=%h ovf=%0b zero=%0b",
               tag, outValid, outWord, outOvf, outZero, sv[4], hW, hO, hZ);
    end
  endtask

  task automatic step(bit v, logic [15:0] a, logic [15:0] b, bit sgn, bit frac,
                      bit sel, logic [1:0] op, logic [1:0] post, string tag);
    longint pa, pb, p, val;
    logic signed [39:0] cur;
    logic [31:0] w;
    bit ov;
    inValid = v; opA = a; opB = b; signedMode = sgn; fracMode = frac;
    accSel = sel; opCode = op; postMode = post;
    @(posedge clk);
    for (int i = 4; i > 1; i--) begin
      sv[i] = sv[i-1]; sw[i] = sw[i-1]; so[i] = so[i-1]; sz[i] = sz[i-1]; st[i] = st[i-1];
    end
    sv[1] = v; st[1] = tag;
    if (v) begin
      pa = sgn ? longint'(signed'(a)) : longint'(a);
      pb = sgn ? longint'(signed'(b)) : longint'(b);
      p = pa * pb;
      if (frac) p = p * 2;
      cur = mAcc[sel];
      case (op)
        2'b00: cur = cur + p[39:0];
        2'b01: cur = cur - p[39:0];
        2'b10: cur = '0;
        default: cur = p[39:0];
      endcase
      mAcc[sel] = cur;
      val = longint'(cur);
      if (post == 2'b01) val = val & ~64'hFFFF;
      else if (post == 2'b10) val = (val + 32768) & ~64'hFFFF;
      ov = 1;
      if (val > 64'sd2147483647) w = 32'h7FFF_FFFF;
      else if (val < -64'sd2147483648) w = 32'h8000_0000;
      else begin w = val[31:0]; ov = 0; end
      sw[1] = w; so[1] = ov; sz[1] = (w == 32'h0);
    end
    if (sv[4]) begin hW = sw[4]; hO = so[4]; hZ = sz[4]; end
    @(negedge clk);
    compare(sv[4] ? st[4] : tag);
  endtask

  task automatic idle(string tag);
    step(0, 16'h0, 16'h0, 0, 0, 0, 2'b00, 2'b00, tag);
  endtask

  task automatic flush(string tag);
    for (int i = 0; i < 3; i++) idle(tag);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mAcc[0] = '0; mAcc[1] = '0;
    for (int i = 1; i <= 4; i++) begin sv[i] = 0; sw[i] = '0; so[i] = 0; sz[i] = 0; st[i] = "R1"; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: outputs cleared by reset
    compare("R1");
    // R1: both accumulators read back as zero
    step(1, 16'h0, 16'h0, 1, 0, 0, 2'b00, 2'b00, "R1");
    step(1, 16'h0, 16'h0, 1, 0, 1, 2'b00, 2'b00, "R1");
    flush("R1");

    // R5 / R3 signed: load, add, subtract, clear
    step(1, 16'd3, 16'hFFFC, 1, 0, 0, 2'b11, 2'b00, "R5");
    step(1, 16'd5, 16'd6,    1, 0, 0, 2'b00, 2'b00, "R5");
    step(1, 16'd2, 16'd2,    1, 0, 0, 2'b01, 2'b00, "R5");
    // R6: accumulator B independent of A
    step(1, 16'hFFF9, 16'hFFF9, 1, 0, 1, 2'b00, 2'b00, "R6");
    step(1, 16'h0, 16'h0, 1, 0, 0, 2'b00, 2'b00, "R6");
    step(1, 16'h0, 16'h0, 1, 0, 0, 2'b10, 2'b00, "R5");
    step(1, 16'h0, 16'h0, 1, 0, 1, 2'b00, 2'b00, "R6");
    // R3: unsigned full scale saturates, signed -1*-1 is 1
    step(1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 2'b11, 2'b00, "R3");
    step(1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 2'b11, 2'b00, "R3");
    step(1, 16'h8000, 16'h8000, 1, 0, 0, 2'b11, 2'b00, "R3");
    // R4: fractional doubling
    step(1, 16'h8000, 16'h8000, 1, 1, 0, 2'b11, 2'b00, "R4");
    step(1, 16'h4000, 16'h4000, 1, 1, 0, 2'b11, 2'b00, "R4");
    // R9: negative clamp
    step(1, 16'h8000, 16'h7FFF, 1, 1, 0, 2'b11, 2'b00, "R9");
    step(1, 16'h8000, 16'h7FFF, 1, 1, 0, 2'b00, 2'b00, "R9");
    flush("R9");

    // R7: guard bits hold out-of-range sums and return to zero
    step(1, 16'h0, 16'h0, 0, 0, 1, 2'b10, 2'b00, "R7");
    for (int i = 0; i < 8; i++) step(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 2'b00, 2'b00, "R7");
    for (int i = 0; i < 8; i++) step(1, 16'hFFFF, 16'hFFFF, 0, 0, 1, 2'b01, 2'b00, "R7");
    // R7: wrap past 2^39
    step(1, 16'hFFFF, 16'hFFFF, 0, 1, 1, 2'b11, 2'b00, "R7");
    for (int i = 0; i < 64; i++) step(1, 16'hFFFF, 16'hFFFF, 0, 1, 1, 2'b00, 2'b00, "R7");
    flush("R7");

    // R8: post-processing modes on 0x12348000
    step(1, 16'h1234, 16'h8000, 0, 1, 0, 2'b11, 2'b00, "R8");
    step(1, 16'h8000, 16'h0001, 0, 0, 0, 2'b00, 2'b00, "R8");
    step(1, 16'h0, 16'h0, 0, 0, 0, 2'b00, 2'b01, "R8");
    step(1, 16'h0, 16'h0, 0, 0, 0, 2'b00, 2'b10, "R8");
    step(1, 16'h0, 16'h0, 0, 0, 0, 2'b00, 2'b11, "R8");
    step(1, 16'h1, 16'h1, 0, 0, 0, 2'b01, 2'b10, "R8");
    // R10: rounding -0x8000 gives zero; truncation floors
    step(1, 16'h0, 16'h0, 0, 0, 0, 2'b10, 2'b00, "R10");
    step(1, 16'h8000, 16'h1, 0, 0, 0, 2'b01, 2'b10, "R10");
    step(1, 16'h0, 16'h0, 0, 0, 0, 2'b00, 2'b01, "R8");
    // R9: rounding carries into saturation
    step(1, 16'h7FFF, 16'h8000, 0, 1, 0, 2'b11, 2'b00, "R9");
    step(1, 16'h8000, 16'h1, 0, 0, 0, 2'b00, 2'b10, "R9");
    flush("R9");
    // R11: outputs hold while idle
    for (int i = 0; i < 5; i++) idle("R11");

    // R2: back-to-back mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[1:0] != 2'b00), 16'($urandom), 16'($urandom), r[2], r[3], r[4],
           r[6:5], r[8:7], "R2");
    end
    flush("R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule